// File: doc/BRIEF.md
# Two-Stage I/Q Automatic Gain Controller

This block sits behind the receive filter chain and closes a gain loop around a coarse front-end gain stage and a fine programmable gain stage. It takes signed baseband I and Q samples, removes DC from each channel, keeps one accepted sample in eight, and measures the combined I/Q power of that thinned stream. It then averages the power over a window of a programmable power-of-two length and issues one gain decision per window. The decision steps the fine gain code by one, and hands over to the coarse stage when the fine code runs into its limits.

DC removal is chosen by a select input. One option is a first-order leaky-integrator high-pass per channel. The other subtracts a stored calibration offset per channel. A master disable input puts both stages under manual control. A second input puts only the coarse stage under manual control while the fine stage stays automatic. The master disable is expected to be held at 1 after reset, and the loop runs only once it is cleared. When the loop is enabled it starts from the manual values, so the gain does not jump.

Top module: `iq_agc`

## Requirements
- R1: While `agc_off` is 1, including during reset, `lna_gain` equals `man_lna`, `pga_gain` equals `man_pga` and `gain_upd` is 0.
- R2: While `agc_off` is 1, `lna_man`, the samples and the power settings do not change the outputs, and no update pulse appears.
- R3: Every sample with `in_valid` high advances a modulo-8 phase counter that starts at 0 after reset and runs whatever the mode. Only a sample accepted at phase 7 is used for power measurement.
- R4: The power of a used sample is yI*yI + yQ*yQ, where yI and yQ are the 16-bit signed DC-removed values. The two channel terms are summed and neither channel is used alone.
- R5: With `dc_hpf` = 0, y = sat16(x - cal) on each channel, using `cal_i` or `cal_q`.
- R6: With `dc_hpf` = 1, y = sat16(x - floor(e/16)). The per-channel state e resets to 0, and on every accepted sample e becomes e + x - floor(e/16). The state is updated in both modes.
- R7: A window holds 2^`avg_log2` used samples. At its last sample the average A = floor(sum/2^`avg_log2`) is formed, the accumulator restarts, and `gain_upd` pulses high for exactly the one following cycle. Outside such pulses the fine gain holds.
- R8: At a decision, if A > `target` + `hyst` the fine gain steps down by one, if A + `hyst` < `target` it steps up by one, and otherwise it holds.
- R9: The fine gain does not step below `pga_min` or above `pga_max`. At a limit, with the coarse stage automatic, the coarse mode steps the same way within 0..3 and the fine gain reloads `pga_mid`. Otherwise the fine gain clamps to the limit.
- R10: With `agc_off` = 0 and `lna_man` = 1, `lna_gain` follows `man_lna` and the fine gain stays automatic with no coarse handoff.
- R11: The cycle after `agc_off` falls, the outputs equal the manual values that were applied while it was 1, and the first window starts with an empty accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample accept strobe |
| in_i | input | 16 | I sample, signed |
| in_q | input | 16 | Q sample, signed |
| dc_hpf | input | 1 | 1: high-pass DC removal, 0: calibration subtraction |
| cal_i | input | 16 | I calibration offset, signed |
| cal_q | input | 16 | Q calibration offset, signed |
| agc_off | input | 1 | Master disable; both stages manual |
| lna_man | input | 1 | Coarse stage manual |
| man_lna | input | 2 | Manual coarse mode |
| man_pga | input | 6 | Manual fine gain code |
| pga_min | input | 6 | Lowest fine gain code |
| pga_max | input | 6 | Highest fine gain code |
| pga_mid | input | 6 | Fine gain reload code on handoff |
| target | input | 32 | Target average power |
| hyst | input | 32 | Hysteresis margin |
| avg_log2 | input | 3 | log2 of the window length in used samples |
| lna_gain | output | 2 | Coarse gain mode |
| pga_gain | output | 6 | Fine gain code |
| gain_upd | output | 1 | One-cycle pulse after each gain decision |

## Verification
The hardest state to reach is the coarse/fine handoff. The fine code must first be driven to a limit, and then a window must close that still pushes the same way. The outcome also depends on whether the coarse stage is automatic at that moment. The stimulus gets there by narrowing the fine limits to a few codes and applying sustained loud, then silent, input, so the coarse mode walks its full range and then saturates in both directions. A randomized reference model in the bench, which covers the high-pass transient, the decimation phase and the window boundaries, is compared with the outputs on every cycle.

// File: rtl/iq_agc.sv
module iq_agc #(
  parameter int DW      = 16,
  parameter int PGA_W   = 6,
  parameter int LNA_W   = 2,
  parameter int LNA_TOP = 3,
  parameter int HPF_SH  = 4,
  parameter int AVG_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [DW-1:0]    in_i,
  input  logic signed [DW-1:0]    in_q,
  input  logic                    dc_hpf,
  input  logic signed [DW-1:0]    cal_i,
  input  logic signed [DW-1:0]    cal_q,
  input  logic                    agc_off,
  input  logic                    lna_man,
  input  logic [LNA_W-1:0]        man_lna,
  input  logic [PGA_W-1:0]        man_pga,
  input  logic [PGA_W-1:0]        pga_min,
  input  logic [PGA_W-1:0]        pga_max,
  input  logic [PGA_W-1:0]        pga_mid,
  input  logic [2*DW-1:0]         target,
  input  logic [2*DW-1:0]         hyst,
  input  logic [AVG_W-1:0]        avg_log2,
  output logic [LNA_W-1:0]        lna_gain,
  output logic [PGA_W-1:0]        pga_gain,
  output logic                    gain_upd
);
  localparam int PW  = 2 * DW;
  localparam int EW  = DW + HPF_SH + 1;
  localparam int CW  = (1 << AVG_W) - 1;
  localparam int ACW = PW + CW;

  logic signed [EW-1:0] est_i, est_q;
  logic [2:0]           dec;
  logic [CW-1:0]        cnt;
  logic [ACW-1:0]       acc;
  logic [LNA_W-1:0]     lna_r, lna_nx;
  logic [PGA_W-1:0]     pga_r, pga_nx;

  function automatic logic signed [DW-1:0] sat(input logic signed [DW:0] v);
    if (v[DW] != v[DW-1]) return {v[DW], {(DW-1){~v[DW]}}};
    return v[DW-1:0];
  endfunction

  // DC removal: leaky-integrator estimate or stored offset
  logic signed [DW-1:0] ei, eq;
  assign ei = est_i[HPF_SH +: DW];
  assign eq = est_q[HPF_SH +: DW];

  logic signed [DW:0] hd_i, hd_q, cd_i, cd_q;
  assign hd_i = $signed({in_i[DW-1], in_i}) - $signed({ei[DW-1], ei});
  assign hd_q = $signed({in_q[DW-1], in_q}) - $signed({eq[DW-1], eq});
  assign cd_i = $signed({in_i[DW-1], in_i}) - $signed({cal_i[DW-1], cal_i});
  assign cd_q = $signed({in_q[DW-1], in_q}) - $signed({cal_q[DW-1], cal_q});

  logic signed [DW-1:0] yi, yq;
  assign yi = sat(dc_hpf ? hd_i : cd_i);
  assign yq = sat(dc_hpf ? hd_q : cd_q);

  logic signed [PW-1:0] sq_i, sq_q;
  logic [PW-1:0]        pwr;
  assign sq_i = PW'(yi) * PW'(yi);
  assign sq_q = PW'(yq) * PW'(yq);
  assign pwr  = $unsigned(sq_i) + $unsigned(sq_q);

  // Window accounting
  logic          take, wend, hi, lo;
  logic [CW-1:0] lastn;
  logic [ACW-1:0] acc_sum;
  logic [PW-1:0]  avg;
  assign take    = in_valid && (dec == 3'd7);
  assign lastn   = (CW'(1) << avg_log2) - CW'(1);
  assign wend    = (cnt == lastn);
  assign acc_sum = acc + ACW'(pwr);
  assign avg     = PW'(acc_sum >> avg_log2);
  assign hi      = {1'b0, avg} > ({1'b0, target} + {1'b0, hyst});
  assign lo      = ({1'b0, avg} + {1'b0, hyst}) < {1'b0, target};

  always_comb begin
    pga_nx = pga_r;
    lna_nx = lna_man ? man_lna : lna_r;
    if (hi) begin
      if (pga_r > pga_min)                           pga_nx = pga_r - 1'b1;
      else if (!lna_man && lna_r != '0)              begin lna_nx = lna_r - 1'b1; pga_nx = pga_mid; end
      else                                           pga_nx = pga_min;
    end else if (lo) begin
      if (pga_r < pga_max)                           pga_nx = pga_r + 1'b1;
      else if (!lna_man && lna_r < LNA_W'(LNA_TOP))  begin lna_nx = lna_r + 1'b1; pga_nx = pga_mid; end
      else                                           pga_nx = pga_max;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      est_i <= '0; est_q <= '0; dec <= '0; cnt <= '0; acc <= '0;
      lna_r <= '0; pga_r <= '0; gain_upd <= 1'b0;
    end else begin
      if (in_valid) begin
        est_i <= est_i + EW'(hd_i);
        est_q <= est_q + EW'(hd_q);
        dec   <= dec + 3'd1;
      end
      gain_upd <= 1'b0;
      if (agc_off) begin
        lna_r <= man_lna; pga_r <= man_pga; acc <= '0; cnt <= '0;
      end else begin
        if (lna_man) lna_r <= man_lna;
        if (take) begin
          if (wend) begin
            acc <= '0; cnt <= '0; gain_upd <= 1'b1;
            pga_r <= pga_nx; lna_r <= lna_nx;
          end else begin
            acc <= acc_sum; cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  assign lna_gain = (agc_off || lna_man) ? man_lna : lna_r;
  assign pga_gain = agc_off ? man_pga : pga_r;

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(agc_off) |-> !gain_upd);

  assert_upd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gain_upd |=> !gain_upd);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pga_r != $past(pga_r)) |-> (gain_upd || $past(agc_off)));

  assert_pga_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!agc_off) && pga_r != $past(pga_r)) |->
      (pga_r == $past(pga_r) + 1'b1 || pga_r == $past(pga_r) - 1'b1 ||
       pga_r == $past(pga_mid) || pga_r == $past(pga_min) || pga_r == $past(pga_max)));

  assert_handoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!agc_off && !lna_man) && lna_r != $past(lna_r)) |-> pga_r == $past(pga_mid));
endmodule

// File: tb/iq_agc_tb_top.sv
`timescale 1ns/1ps
module iq_agc_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, dc_hpf, agc_off, lna_man, gain_upd;
  logic signed [15:0] in_i, in_q, cal_i, cal_q;
  logic [1:0]  man_lna, lna_gain;
  logic [5:0]  man_pga, pga_min, pga_max, pga_mid, pga_gain;
  logic [31:0] target, hyst;
  logic [2:0]  avg_log2;

  iq_agc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .dc_hpf(dc_hpf), .cal_i(cal_i), .cal_q(cal_q), .agc_off(agc_off), .lna_man(lna_man),
    .man_lna(man_lna), .man_pga(man_pga), .pga_min(pga_min), .pga_max(pga_max),
    .pga_mid(pga_mid), .target(target), .hyst(hyst), .avg_log2(avg_log2),
    .lna_gain(lna_gain), .pga_gain(pga_gain), .gain_upd(gain_upd)
  );

  int ntest = 0, nfail = 0;
  string cur_req = "R1";
  bit rnd = 1'b1;
  int amp = 1000, dci = 0, dcq = 0;

  // reference model
  longint m_ei = 0, m_eq = 0, m_acc = 0;
  int m_dec = 0, m_cnt = 0, m_lna = 0, m_pga = 0;
  bit m_upd = 0;
  int m_upd_n = 0, d_upd_n = 0;

  function automatic longint satv(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  always @(posedge clk) begin
    longint yi, yq, p, a;
    bit last;
    if (!rst_n) begin
      m_ei = 0; m_eq = 0; m_acc = 0; m_dec = 0; m_cnt = 0; m_lna = 0; m_pga = 0; m_upd = 0;
    end else begin
      last = 0; p = 0;
      if (in_valid) begin
        yi = dc_hpf ? satv(longint'(in_i) - (m_ei >>> 4)) : satv(longint'(in_i) - longint'(cal_i));
        yq = dc_hpf ? satv(longint'(in_q) - (m_eq >>> 4)) : satv(longint'(in_q) - longint'(cal_q));
        p = yi * yi + yq * yq;
        last = (m_dec == 7);
        m_ei = m_ei + longint'(in_i) - (m_ei >>> 4);
        m_eq = m_eq + longint'(in_q) - (m_eq >>> 4);
        m_dec = (m_dec + 1) % 8;
      end
      m_upd = 0;
      if (agc_off) begin
        m_lna = man_lna; m_pga = man_pga; m_acc = 0; m_cnt = 0;
      end else begin
        if (lna_man) m_lna = man_lna;
        if (last) begin
          if (m_cnt == (1 << avg_log2) - 1) begin
            a = (m_acc + p) >> avg_log2;
            m_acc = 0; m_cnt = 0; m_upd = 1; m_upd_n++;
            if (a > longint'(target) + longint'(hyst)) begin
              if (m_pga > pga_min) m_pga--;
              else if (!lna_man && m_lna > 0) begin m_lna--; m_pga = pga_mid; end
              else m_pga = pga_min;
            end else if (a + longint'(hyst) < longint'(target)) begin
              if (m_pga < pga_max) m_pga++;
              else if (!lna_man && m_lna < 3) begin m_lna++; m_pga = pga_mid; end
              else m_pga = pga_max;
            end
          end else begin
            m_acc = m_acc + p; m_cnt++;
          end
        end
      end
    end
  end

  task automatic check(string tag, longint act, longint exp, string what);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [15:0] smp(int dc);
    return 16'(satv(longint'(dc) + longint'($urandom % (2 * amp + 1)) - amp));
  endfunction

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      check(cur_req, lna_gain, (agc_off || lna_man) ? man_lna : m_lna, "lna_gain");
      check(cur_req, pga_gain, agc_off ? man_pga : m_pga, "pga_gain");
      check(cur_req, gain_upd, m_upd, "gain_upd");
    end
    if (gain_upd) d_upd_n++;
    if (rnd) begin
      in_valid = ($urandom % 4) != 0;
      in_i = smp(dci);
      in_q = smp(dcq);
    end else in_valid = 1'b1;
  endtask

  task automatic run(int n);
    repeat (n) tick();
  endtask

  task automatic restart(int l, int p);
    agc_off = 1'b1; man_lna = 2'(l); man_pga = 6'(p);
    run(2);
    agc_off = 1'b0;
    run(1);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", ntest);
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    int p0;
    void'($urandom(32'd1234));
    rst_n = 0; in_valid = 0; in_i = 0; in_q = 0; dc_hpf = 0; cal_i = 0; cal_q = 0;
    agc_off = 1; lna_man = 0; man_lna = 2; man_pga = 30;
    pga_min = 4; pga_max = 56; pga_mid = 30;
    target = 32'd20_000_000; hyst = 32'd1_000_000; avg_log2 = 2;
    repeat (3) @(negedge clk);
    // R1: reset state follows manual values
    check("R1", lna_gain, 2, "lna_gain in reset");
    check("R1", pga_gain, 30, "pga_gain in reset");
    check("R1", gain_upd, 0, "gain_upd in reset");
    rst_n = 1;
    run(4);

    // R2: disabled loop ignores lna_man and signal
    cur_req = "R2";
    amp = 15000;
    for (int k = 0; k < 20; k++) begin
      lna_man = k[0]; man_pga = 6'($urandom % 64); man_lna = 2'($urandom % 4);
      run(20);
    end
    check("R2", d_upd_n, 0, "update pulses while disabled");
    lna_man = 0;

    // R11: enable starts from manual values
    cur_req = "R11";
    man_lna = 1; man_pga = 25;
    run(2);
    agc_off = 0;
    run(1);
    check("R11", lna_gain, 1, "lna right after enable");
    check("R11", pga_gain, 25, "pga right after enable");

    // R8 / R9: loud random input drives gain down across coarse modes
    cur_req = "R8";
    amp = 12000;
    run(1500);
    check("R9", lna_gain, 0, "coarse mode after long loud input");

    // R4: power is the sum of both channels
    cur_req = "R4";
    rnd = 0; dc_hpf = 0; cal_i = 0; cal_q = 0; avg_log2 = 0;
    target = 32'd9_000_000; hyst = 32'd100;
    in_i = 3000; in_q = 0;
    restart(1, 30);
    run(100);
    check("R4", pga_gain, 30, "I-only power at target holds");
    in_i = 0; in_q = 3000;
    run(100);
    check("R4", pga_gain, 30, "Q-only power at target holds");
    in_i = 3000; in_q = 3000;
    run(100);
    check("R4", pga_gain < 30, 1, "I+Q power above target lowers gain");

    // R5: calibration offset subtraction
    cur_req = "R5";
    target = 32'd1_000_000; hyst = 32'd100_000;
    in_i = 5000; in_q = -5000; cal_i = 5000; cal_q = -5000;
    restart(1, 30);
    run(100);
    check("R5", pga_gain > 30, 1, "offset fully removed raises gain");
    cal_i = 0; cal_q = 0;
    restart(1, 30);
    run(100);
    check("R5", pga_gain < 30, 1, "no offset removed lowers gain");

    // R6: high-pass removes a large DC level after settling
    cur_req = "R6";
    dc_hpf = 1; in_i = 20000; in_q = -20000;
    restart(1, 30);
    run(2500);
    check("R6", lna_gain, 3, "coarse mode after HPF settles");
    check("R6", pga_gain, 56, "fine gain after HPF settles");

    // R7: one update per window of 2^avg_log2 used samples
    cur_req = "R7";
    avg_log2 = 3;
    run(1);
    p0 = d_upd_n;
    run(640);
    check("R7", d_upd_n - p0, 10, "updates in 640 valid cycles, window 64");

    // R3: decimation phase under random strobes and windows
    cur_req = "R3";
    rnd = 1; dc_hpf = 0; amp = 4000; avg_log2 = 1;
    target = 32'd5_000_000; hyst = 32'd500_000;
    for (int k = 0; k < 6; k++) begin
      dci = int'($urandom % 2000) - 1000;
      avg_log2 = 3'($urandom % 4);
      run(300);
    end
    check("R3", d_upd_n, m_upd_n, "total update pulses");

    // R9: narrow limits, handoff then saturation both ways
    cur_req = "R9";
    pga_min = 10; pga_max = 14; pga_mid = 12; avg_log2 = 1; dci = 0;
    amp = 15000; target = 32'd20_000_000; hyst = 32'd1_000_000;
    restart(3, 12);
    run(1200);
    check("R9", lna_gain, 0, "coarse floor");
    check("R9", pga_gain, 10, "fine floor");
    amp = 0;
    run(1200);
    check("R9", lna_gain, 3, "coarse ceiling");
    check("R9", pga_gain, 14, "fine ceiling");

    // R10: coarse stage manual, fine stage clamps without handoff
    cur_req = "R10";
    lna_man = 1; man_lna = 2;
    restart(2, 12);
    run(600);
    check("R10", lna_gain, 2, "manual coarse mode kept");
    check("R10", pga_gain, 14, "fine gain clamped at max");
    amp = 15000;
    run(600);
    check("R10", lna_gain, 2, "manual coarse mode kept loud");
    check("R10", pga_gain, 10, "fine gain clamped at min");

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule